// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block is the flag stage of a 32-bit integer ALU. It takes two operands, a four-bit operation code and an external carry bit. It produces the operation's result combinationally. It also keeps six condition flags in a register: carry, zero, sign, overflow, parity and auxiliary carry. Each flag follows the rule of the operation class that produced the result.

The flag register is written only on a clock edge where the update enable is high and the operation code is defined. This lets the surrounding pipeline compute a result without disturbing the stored condition state, for example for address arithmetic or a squashed instruction. Increment and decrement leave the stored carry untouched. The logical operations force carry, overflow and auxiliary carry to zero.

Top module: `status_flag_unit`

## Requirements
- R1: For operation codes ADD=0, ADC=1, SUB=2, SBB=3, INC=7 and DEC=8, `result` is, modulo 2^32, opA+opB, opA+opB+carryIn, opA-opB, opA-opB-carryIn, opA+1 and opA-1 respectively. opB has no effect on INC or DEC, and carryIn affects only ADC and SBB.
- R2: For AND=4, OR=5 and XOR=6, `result` is the bitwise AND, OR or XOR of opA and opB.
- R3: Flag bit 0 (carry) takes the unsigned carry out of the top bit for ADD and ADC. It takes the borrow, meaning the subtrahend plus incoming carry exceeds opA, for SUB and SBB.
- R4: Flag bit 1 (zero) is set when all 32 result bits are 0.
- R5: Flag bit 2 (sign) copies result bit 31.
- R6: Flag bit 3 (overflow) is set when the exact signed result of an arithmetic operation lies outside -2^31 to 2^31-1.
- R7: Flag bit 4 (parity) is set when result bits 7:0 hold an even number of ones.
- R8: Flag bit 5 (auxiliary carry) is set on a carry out of bit 3 for additions, or a borrow into bit 4 for subtractions. INC and DEC count as an addition or subtraction of 1.
- R9: AND, OR and XOR clear the carry, overflow and auxiliary carry flags.
- R10: INC and DEC write every flag except carry, which keeps its stored value.
- R11: The flag register changes only on a rising clock edge with updateEn high; with updateEn low every flag holds.
- R12: While rstN is low all six flags read 0.
- R13: Operation codes 9 to 15 give a result of 0 and never write the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| opSel | input | 4 | Operation code |
| carryIn | input | 1 | Incoming carry for ADC and SBB |
| updateEn | input | 1 | Write the flag register at this edge |
| result | output | 32 | Combinational result |
| flags | output | 6 | Registered flags {aux, parity, overflow, sign, zero, carry} |

## Verification
The bench goes after the signed boundary at 0x7FFFFFFF/0x80000000. A wrong overflow term would flag there in the wrong direction, or not at all. It also targets the all-ones plus one wrap, where carry, zero and auxiliary carry must all set together, and subtractions with a nonzero incoming carry, where a design that ignores carryIn in the borrow would miss a borrow. INC after a set carry and DEC through zero expose a design that overwrites carry. Held cycles and undefined codes expose a register that writes without the enable.

// File: rtl/sfu_pkg.sv
package sfu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBB = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_INC = 4'd7,
    OP_DEC = 4'd8
  } aluOp_e;

  localparam int FLAG_COUNT = 6;
  localparam int FLAG_CARRY = 0;
  localparam int FLAG_ZERO  = 1;
  localparam int FLAG_SIGN  = 2;
  localparam int FLAG_OVF   = 3;
  localparam int FLAG_PAR   = 4;
  localparam int FLAG_AUX   = 5;
  localparam int PARITY_BITS = 8;
  localparam int AUX_BIT     = 4;

  // logicSel encodings
  localparam logic [1:0] LSEL_AND  = 2'd0;
  localparam logic [1:0] LSEL_OR   = 2'd1;
  localparam logic [1:0] LSEL_XOR  = 2'd2;
  localparam logic [1:0] LSEL_NONE = 2'd3;

  typedef struct packed {
    logic       arith;
    logic       subtract;
    logic       useCarry;
    logic       incDec;
    logic [1:0] logicSel;
    logic       holdCarry;
    logic       writeFlags;
  } ctrlStrobe_t;

endpackage

// File: rtl/sfu_ctrl.sv
module sfu_ctrl
  import sfu_pkg::*;
(
  input  logic [3:0]  opSel,
  input  logic        updateEn,
  output ctrlStrobe_t strobe
);

  logic validOp;

  always_comb begin
    strobe = '{arith: 1'b0, subtract: 1'b0, useCarry: 1'b0, incDec: 1'b0,
               logicSel: LSEL_NONE, holdCarry: 1'b0, writeFlags: 1'b0};
    validOp = 1'b1;
    case (opSel)
      OP_ADD: strobe.arith = 1'b1;
      OP_ADC: begin strobe.arith = 1'b1; strobe.useCarry = 1'b1; end
      OP_SUB: begin strobe.arith = 1'b1; strobe.subtract = 1'b1; end
      OP_SBB: begin
        strobe.arith = 1'b1; strobe.subtract = 1'b1; strobe.useCarry = 1'b1;
      end
      OP_AND: strobe.logicSel = LSEL_AND;
      OP_OR:  strobe.logicSel = LSEL_OR;
      OP_XOR: strobe.logicSel = LSEL_XOR;
      OP_INC: begin
        strobe.arith = 1'b1; strobe.incDec = 1'b1; strobe.holdCarry = 1'b1;
      end
      OP_DEC: begin
        strobe.arith = 1'b1; strobe.subtract = 1'b1; strobe.incDec = 1'b1;
        strobe.holdCarry = 1'b1;
      end
      default: validOp = 1'b0;
    endcase
    strobe.writeFlags = updateEn & validOp;
  end

endmodule

// File: rtl/sfu_datapath.sv
module sfu_datapath
  import sfu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [WIDTH-1:0]      opA,
  input  logic [WIDTH-1:0]      opB,
  input  logic                  carryIn,
  input  ctrlStrobe_t           strobe,
  output logic [WIDTH-1:0]      result,
  output logic [FLAG_COUNT-1:0] flags
);

  localparam int MSB = WIDTH - 1;
  localparam int EXT = WIDTH + 1;

  logic [WIDTH-1:0]      operandB;
  logic [EXT-1:0]        extSum;
  logic [WIDTH-1:0]      logicRes;
  logic [WIDTH-1:0]      halfXor;
  logic                  cinBit;
  logic [FLAG_COUNT-1:0] flagNext;
  logic [FLAG_COUNT-1:0] flagQ;

  always_comb begin
    operandB = strobe.incDec ? WIDTH'(1) : opB;
    cinBit   = strobe.useCarry & carryIn;
    if (strobe.subtract)
      extSum = {1'b0, opA} - {1'b0, operandB} - EXT'(cinBit);
    else
      extSum = {1'b0, opA} + {1'b0, operandB} + EXT'(cinBit);
  end

  always_comb begin
    case (strobe.logicSel)
      LSEL_AND: logicRes = opA & opB;
      LSEL_OR:  logicRes = opA | opB;
      LSEL_XOR: logicRes = opA ^ opB;
      default:  logicRes = '0;
    endcase
  end

  assign result  = strobe.arith ? extSum[MSB:0] : logicRes;
  assign halfXor = opA ^ operandB ^ result;

  always_comb begin
    flagNext[FLAG_ZERO] = (result == '0);
    flagNext[FLAG_SIGN] = result[MSB];
    flagNext[FLAG_PAR]  = ~^result[PARITY_BITS-1:0];
    if (strobe.arith) begin
      flagNext[FLAG_CARRY] = strobe.holdCarry ? flagQ[FLAG_CARRY] : extSum[WIDTH];
      if (strobe.subtract)
        flagNext[FLAG_OVF] = (opA[MSB] ^ operandB[MSB]) & (result[MSB] ^ opA[MSB]);
      else
        flagNext[FLAG_OVF] = ~(opA[MSB] ^ operandB[MSB]) & (result[MSB] ^ opA[MSB]);
      flagNext[FLAG_AUX] = halfXor[AUX_BIT];
    end else begin
      flagNext[FLAG_CARRY] = 1'b0;
      flagNext[FLAG_OVF]   = 1'b0;
      flagNext[FLAG_AUX]   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  flagQ <= '0;
    else if (strobe.writeFlags) flagQ <= flagNext;
  end

  assign flags = flagQ;

endmodule

// File: rtl/status_flag_unit.sv
module status_flag_unit
  import sfu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [WIDTH-1:0]      opA,
  input  logic [WIDTH-1:0]      opB,
  input  logic [3:0]            opSel,
  input  logic                  carryIn,
  input  logic                  updateEn,
  output logic [WIDTH-1:0]      result,
  output logic [FLAG_COUNT-1:0] flags
);

  ctrlStrobe_t strobe;

  sfu_ctrl u_ctrl (
    .opSel    (opSel),
    .updateEn (updateEn),
    .strobe   (strobe)
  );

  sfu_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .opA     (opA),
    .opB     (opB),
    .carryIn (carryIn),
    .strobe  (strobe),
    .result  (result),
    .flags   (flags)
  );

endmodule

// File: rtl/status_flag_checker.sv
module status_flag_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic [3:0]       opSel,
  input logic             updateEn,
  input logic [WIDTH-1:0] result,
  input logic [5:0]       flags
);

  logic writeReq;
  assign writeReq = updateEn && (opSel <= 4'd8);

  // R11
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !updateEn |=> $stable(flags));

  // R13
  bad_code_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (updateEn && opSel > 4'd8) |=> $stable(flags));

  // R4
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    writeReq |=> flags[1] == ($past(result) == '0));

  // R5
  sign_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    writeReq |=> flags[2] == $past(result[WIDTH-1]));

  // R7
  parity_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    writeReq |=> flags[4] == ~^$past(result[7:0]));

  // R9
  logic_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (updateEn && opSel >= 4'd4 && opSel <= 4'd6) |=>
      (flags[0] == 1'b0 && flags[3] == 1'b0 && flags[5] == 1'b0));

  // R10
  incdec_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (updateEn && (opSel == 4'd7 || opSel == 4'd8)) |=> $stable(flags[0]));

  // R13
  bad_code_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opSel > 4'd8) |-> result == '0);

endmodule

bind status_flag_unit status_flag_checker #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .opSel    (opSel),
  .updateEn (updateEn),
  .result   (result),
  .flags    (flags)
);

// File: tb/status_flag_unit_test.sv
module status_flag_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic [3:0]  opSel = 4'd0;
  logic        carryIn = 1'b0, updateEn = 1'b0;
  logic [31:0] result;
  logic [5:0]  flags;

  int testCount = 0, failCount = 0;
  logic [5:0] expFlags = '0;
  bit finished = 0;

  always #10 clk = ~clk;

  status_flag_unit uut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .opSel(opSel),
    .carryIn(carryIn), .updateEn(updateEn), .result(result), .flags(flags)
  );

  function automatic string flagTag(int i);
    case (i)
      0: return "R3 carry";
      1: return "R4 zero";
      2: return "R5 sign";
      3: return "R6 overflow";
      4: return "R7 parity";
      default: return "R8 aux";
    endcase
  endfunction

  function automatic logic [31:0] refResult(logic [3:0] op, logic [31:0] a,
                                            logic [31:0] b, logic c);
    case (op)
      4'd0: return a + b;
      4'd1: return a + b + 32'(c);
      4'd2: return a - b;
      4'd3: return a - b - 32'(c);
      4'd4: return a & b;
      4'd5: return a | b;
      4'd6: return a ^ b;
      4'd7: return a + 32'd1;
      4'd8: return a - 32'd1;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [5:0] refFlags(logic [3:0] op, logic [31:0] a,
                                          logic [31:0] b, logic c, logic prevC);
    logic [31:0] r = refResult(op, a, b, c);
    logic [31:0] bb = (op == 4'd7 || op == 4'd8) ? 32'd1 : b;
    longint cc = (op == 4'd1 || op == 4'd3) ? longint'(c) : 0;
    longint sa = longint'($signed(a)), sb = longint'($signed(bb));
    longint ua = longint'({32'd0, a}), ub = longint'({32'd0, bb});
    longint sr;
    logic cf, of, af;
    bit isSub = (op == 4'd2 || op == 4'd3 || op == 4'd8);
    if (op >= 4'd4 && op <= 4'd6) begin
      cf = 0; of = 0; af = 0;
    end else begin
      if (isSub) begin
        sr = sa - sb - cc;
        cf = ua < ub + cc;
        af = longint'(a[3:0]) < longint'(bb[3:0]) + cc;
      end else begin
        sr = sa + sb + cc;
        cf = ua + ub + cc > 64'hFFFF_FFFF;
        af = longint'(a[3:0]) + longint'(bb[3:0]) + cc > 15;
      end
      of = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      if (op == 4'd7 || op == 4'd8) cf = prevC;
    end
    return {af, ($countones(r[7:0]) % 2 == 0), of, r[31], (r == 32'd0), cf};
  endfunction

  task automatic checkFlags(string ctx);
    testCount++;
    if (flags !== expFlags) begin
      failCount++;
      for (int i = 0; i < 6; i++)
        if (flags[i] !== expFlags[i])
          $display("FAIL %s %s: got %b expected %b", flagTag(i), ctx, flags[i], expFlags[i]);
    end
  endtask

  task automatic runOp(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                       logic c, logic en, string ctx);
    logic [31:0] expR;
    @(negedge clk);
    opSel = op; opA = a; opB = b; carryIn = c; updateEn = en;
    #5;
    expR = refResult(op, a, b, c);
    testCount++;
    if (result !== expR) begin
      failCount++;
      // R1 arithmetic, R2 logic, R13 undefined codes
      $display("FAIL %s result %s: got %h expected %h",
               (op <= 4'd3 || op >= 4'd7 && op <= 4'd8) ? "R1" :
               (op <= 4'd6) ? "R2" : "R13", ctx, result, expR);
    end
    if (en && op <= 4'd8) expFlags = refFlags(op, a, b, c, expFlags[0]);
    @(posedge clk); #1;
    checkFlags(ctx);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R12: reset holds flags at zero even with a write requested
    opSel = 4'd2; opA = 32'd0; opB = 32'd1; updateEn = 1'b1;
    repeat (3) @(posedge clk);
    #1; expFlags = '0; checkFlags("R12 during reset");
    @(negedge clk); rstN = 1'b1; updateEn = 1'b0;
    @(posedge clk); #1; checkFlags("R12 after release");

    runOp(4'd0, 32'h7FFF_FFFF, 32'd1, 1'b0, 1'b1, "R6 positive overflow add");
    runOp(4'd0, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b1, "R3 R4 R8 wrap to zero");
    runOp(4'd1, 32'hFFFF_FFFE, 32'd1, 1'b1, 1'b1, "R1 ADC with carry");
    runOp(4'd2, 32'd0, 32'd1, 1'b0, 1'b1, "R3 borrow");
    runOp(4'd3, 32'd5, 32'd5, 1'b1, 1'b1, "R3 SBB borrow from carryIn");
    runOp(4'd2, 32'h8000_0000, 32'd1, 1'b1, 1'b1, "R6 SUB negative overflow");
    // carry is set now; INC must keep it (R10)
    runOp(4'd0, 32'hFFFF_FFFF, 32'd2, 1'b0, 1'b1, "set carry");
    runOp(4'd7, 32'h0000_000F, 32'hDEAD_BEEF, 1'b0, 1'b1, "R10 INC keeps carry, R8 aux");
    runOp(4'd8, 32'h8000_0000, 32'd7, 1'b1, 1'b1, "R10 DEC overflow");
    runOp(4'd4, 32'hFFFF_FF6A, 32'h0000_00FF, 1'b1, 1'b1, "R7 R9 AND parity");
    runOp(4'd5, 32'h8000_0000, 32'h0000_0001, 1'b0, 1'b1, "R2 OR sign");
    runOp(4'd6, 32'h1234_5678, 32'h1234_5678, 1'b0, 1'b1, "R9 XOR zero");
    runOp(4'd0, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0, "R11 no write");
    runOp(4'd9, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b1, "R13 code 9");
    runOp(4'd15, 32'h0, 32'h0, 1'b1, 1'b1, "R13 code 15");

    for (int n = 0; n < 600; n++) begin
      logic [3:0] op = 4'($urandom_range(0, 9));
      logic [31:0] a = $urandom(), b = $urandom();
      if (n % 7 == 0) a = {$urandom_range(0, 1) ? 1'b1 : 1'b0, 31'h7FFF_FFFF};
      if (n % 11 == 0) b = a;
      runOp(op, a, b, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0),
            "random");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule